// File: doc/BRIEF.md
# Strip Cluster Encoder

This block takes one group of 64 silicon strip channels per bunch-crossing clock, one above-threshold bit per strip. It looks for clusters, meaning maximal runs of neighbouring active strips, and drops any cluster that is wider than a programmable strip count. It reports the surviving clusters as a short list of encoded positions. A full result comes out for every crossing. There is no scanning state machine. Each strip decides locally, from a small window of its neighbours, whether it opens a cluster and whether that cluster passes the width cut.

The position code is written in half-strip units: `2*first + width - 1`. This puts the centre of odd-width clusters on a strip and the centre of even-width clusters between two strips. A downstream stage that correlates clusters found in two stacked sensors can compare these codes directly. The list has a fixed number of slots, filled in ascending strip order. If there are more accepted clusters than slots, an overflow flag is raised. The crossing number travels through the block with the data, so every result stays tied to the crossing it came from.

Top module: `strip_cluster_encoder`

## Requirements
- R1: A crossing with no active strips produces, one cycle later, no valid slot and a low overflow flag.
- R2: A cluster is a maximal run of adjacent active strips. Strip 0 and strip 63 are not neighbours, so runs touching either edge are ordinary clusters and never join across the edges.
- R3: Slot k carries its position on bits [7k+6:7k] of `cl_addr_o`. The position equals 2*first + width - 1, where first is the lowest strip of the cluster.
- R4: When `width_limit_i` holds a value L from 1 to 7, a cluster of width L is reported and a cluster wider than L is dropped.
- R5: When `width_limit_i` is 0, the cut is disabled, and clusters of any width are reported, up to a run covering all 64 strips (position 63).
- R6: Accepted clusters fill slots in ascending strip order starting at slot 0. The valid bits form a contiguous block from bit 0, and empty slots read zero.
- R7: When more than 8 clusters pass the cut, the first 8 are reported and `overflow_o` is 1. Dropped clusters never take a slot and never cause overflow.
- R8: Results appear one clock after the hits. `bx_o` equals the `bx_i` value that came with those hits, and a new crossing is accepted on every clock.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hits_i | input | 64 | Above-threshold bit per strip, bit i is strip i |
| width_limit_i | input | 3 | Largest accepted cluster width, 0 disables the cut |
| bx_i | input | 12 | Crossing number of the current hits |
| cl_valid_o | output | 8 | Valid bit per cluster slot |
| cl_addr_o | output | 56 | Packed 7-bit cluster positions, slot 0 in the low bits |
| overflow_o | output | 1 | More accepted clusters than slots in this crossing |
| bx_o | output | 12 | Crossing number of the reported result |

## Verification
The width cut and the slot overflow can act in the same crossing. The cut decides which clusters count toward the slot limit, so an error in either shows up as a wrong overflow flag or a shifted slot list. The bench provokes this with patterns that mix many single-strip clusters with wide runs under a small limit, both directed (eight singles plus a rejected wide run, nine singles under limit 1) and random, with dense hit vectors and random limits. Each crossing is judged against a bench model that rebuilds the cluster list from the hit vector on its own. Valid bits, packed positions, overflow flag and crossing number are compared one cycle later.

// File: rtl/strip_cluster_encoder.sv
module strip_cluster_encoder #(
  parameter int N_STRIPS = 64,
  parameter int MAX_CL   = 8,
  parameter int LIM_W    = 3,
  parameter int BX_W     = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_STRIPS-1:0]        hits_i,
  input  logic [LIM_W-1:0]           width_limit_i,
  input  logic [BX_W-1:0]            bx_i,
  output logic [MAX_CL-1:0]          cl_valid_o,
  output logic [MAX_CL*(($clog2(N_STRIPS))+1)-1:0] cl_addr_o,
  output logic                       overflow_o,
  output logic [BX_W-1:0]            bx_o
);

  localparam int IDX_W  = $clog2(N_STRIPS);
  localparam int ADDR_W = IDX_W + 1;
  localparam int CNT_W  = IDX_W + 1;
  localparam int WIN    = 1 << LIM_W;

  logic [N_STRIPS-1:0]     start;
  logic [N_STRIPS-1:0]     accept;
  logic [N_STRIPS+WIN-1:0] hpad;
  logic [IDX_W-1:0]        last_idx [N_STRIPS];
  logic [LIM_W:0]          sat_w    [N_STRIPS];

  logic [MAX_CL-1:0]        nxt_valid;
  logic [MAX_CL*ADDR_W-1:0] nxt_addr;
  logic                     nxt_ovf;
  logic [CNT_W-1:0]         cnt;

  assign hpad  = {{WIN{1'b0}}, hits_i};
  assign start = hits_i & ~(hits_i << 1);

  assign last_idx[N_STRIPS-1] = IDX_W'(N_STRIPS-1);

  for (genvar i = 0; i < N_STRIPS; i++) begin : g_strip
    if (i < N_STRIPS-1) begin : g_chain
      assign last_idx[i] = hits_i[i+1] ? last_idx[i+1] : IDX_W'(i);
    end

    always_comb begin
      logic run;
      run      = 1'b1;
      sat_w[i] = '0;
      for (int j = 0; j < WIN; j++) begin
        if (run && hpad[i+j]) sat_w[i] = sat_w[i] + (LIM_W+1)'(1);
        else                  run      = 1'b0;
      end
    end

    assign accept[i] = start[i] &&
                       ((width_limit_i == '0) || (sat_w[i] <= {1'b0, width_limit_i}));
  end

  always_comb begin
    nxt_valid = '0;
    nxt_addr  = '0;
    cnt       = '0;
    for (int i = 0; i < N_STRIPS; i++) begin
      if (accept[i]) begin
        for (int k = 0; k < MAX_CL; k++) begin
          if (cnt == CNT_W'(k)) begin
            nxt_valid[k]                  = 1'b1;
            nxt_addr[k*ADDR_W +: ADDR_W]  = ADDR_W'(i) + ADDR_W'(last_idx[i]);
          end
        end
        cnt = cnt + CNT_W'(1);
      end
    end
    nxt_ovf = (cnt > CNT_W'(MAX_CL));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_valid_o <= '0;
      cl_addr_o  <= '0;
      overflow_o <= 1'b0;
      bx_o       <= '0;
    end else begin
      cl_valid_o <= nxt_valid;
      cl_addr_o  <= nxt_addr;
      overflow_o <= nxt_ovf;
      bx_o       <= bx_i;
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_empty_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(hits_i) == '0) |-> (cl_valid_o == '0 && !overflow_o));

  assert_valid_packed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cl_valid_o + MAX_CL'(1)) & cl_valid_o) == '0);

  assert_ovf_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (&cl_valid_o));

  assert_bx_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (bx_o == $past(bx_i)));

  assert_lim1_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(width_limit_i) == LIM_W'(1)) |-> (cl_valid_o[0] -> !cl_addr_o[0]));

  for (genvar k = 1; k < MAX_CL; k++) begin : g_order
    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cl_valid_o[k] |-> (cl_addr_o[k*ADDR_W +: ADDR_W] > cl_addr_o[(k-1)*ADDR_W +: ADDR_W]));
  end

endmodule

// File: tb/test_strip_cluster_encoder.sv
module test_strip_cluster_encoder;
  localparam int N = 64;
  localparam int S = 8;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  hits;
  logic [2:0]    lim;
  logic [11:0]   bx;
  logic [S-1:0]  v_o;
  logic [S*AW-1:0] a_o;
  logic          ovf_o;
  logic [11:0]   bx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit              pend = 0;
  logic [S-1:0]    e_v;
  logic [S*AW-1:0] e_a;
  logic            e_ovf;
  logic [11:0]     e_bx;
  string           e_tag;

  always #2 clk = ~clk;

  strip_cluster_encoder i_strip_cluster_encoder (
    .clk(clk), .rst_n(rst_n), .hits_i(hits), .width_limit_i(lim), .bx_i(bx),
    .cl_valid_o(v_o), .cl_addr_o(a_o), .overflow_o(ovf_o), .bx_o(bx_o));

  function automatic void model(input logic [N-1:0] h, input logic [2:0] l,
                                output logic [S-1:0] v, output logic [S*AW-1:0] a,
                                output logic o);
    int n = 0;
    v = '0; a = '0; o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (h[i] && (i == 0 || !h[i-1])) begin
        int w = 0;
        while (i + w < N && h[i+w]) w++;
        if (l == 0 || w <= int'(l)) begin
          if (n < S) begin
            v[n] = 1'b1;
            a[n*AW +: AW] = AW'(2*i + w - 1);
          end
          n++;
        end
      end
    end
    o = (n > S);
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] h, input logic [2:0] l, input string tag);
    @(negedge clk);
    if (pend) begin
      chk(e_tag, "valid", 64'(v_o), 64'(e_v));
      chk(e_tag, "addr", 64'(a_o), 64'(e_a));
      chk(e_tag, "overflow", 64'(ovf_o), 64'(e_ovf));
      chk("R8", "bx", 64'(bx_o), 64'(e_bx));
    end
    hits = h; lim = l; bx = bx + 12'd1;
    model(h, l, e_v, e_a, e_ovf);
    e_bx = bx; e_tag = tag; pend = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] r;
    void'($urandom(32'd4711));
    rst_n = 1'b0; hits = '1; lim = 3'd0; bx = 12'd5;
    repeat (3) @(negedge clk);
    chk("R9", "reset valid", 64'(v_o), 64'd0);
    chk("R9", "reset addr", 64'(a_o), 64'd0);
    chk("R9", "reset overflow", 64'(ovf_o), 64'd0);
    chk("R9", "reset bx", 64'(bx_o), 64'd0);
    rst_n = 1'b1;

    step('0, 3'd0, "R1");
    step(64'h8000_0000_0000_0001, 3'd0, "R2");
    step(64'h0000_0000_0000_0400, 3'd0, "R3");
    step(64'h0000_0000_0000_0C00, 3'd0, "R3");
    step(64'h0000_0000_0070_0000, 3'd0, "R3");
    step(64'h0000_0000_00F0_0070, 3'd3, "R4");
    step(64'h0000_0000_0000_0C01, 3'd1, "R4");
    step('1, 3'd0, "R5");
    step('1, 3'd7, "R4");
    step(64'h5555_5555_5555_5555, 3'd0, "R7");
    step(64'h0000_0000_7FF0_5555, 3'd2, "R7");
    step(64'h0000_0000_0001_5555, 3'd1, "R7");
    step(64'h0000_0000_0001_5555, 3'd0, "R7");
    step('0, 3'd0, "R1");

    for (int t = 0; t < 600; t++) begin
      case (t % 4)
        0: r = {$urandom, $urandom};
        1: r = {$urandom, $urandom} & {$urandom, $urandom};
        2: r = {$urandom, $urandom} | {$urandom, $urandom};
        default: r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      endcase
      step(r, 3'($urandom), "R6");
    end
    step('0, 3'd0, "R1");
    step('0, 3'd0, "R1");
    finish_run();
  end
endmodule